// File: doc/BRIEF.md
# Multi-Bank Chip-Select Address Decoder

This block sits beside an external bus interface and decides, for each bus request, which of four programmable memory banks the access belongs to. Every bank holds a 17-bit base address with a per-bit compare mask, a 3-bit address-type code with its own mask, a valid flag and a write-protect flag. A request presents a 32-bit address, a 3-bit address type, a read/write flag and a flag saying that an external bus master issued it. The block compares the upper 17 address bits and the type against every bank and registers the result one clock later. The result is a hit flag, a one-hot chip-select enable and the index of the chosen bank.

When banks overlap, the lowest-numbered match owns the access. A write that lands on a protected owner is refused and logged in a sticky per-bank error vector, which software clears bit by bit by writing ones. After reset the decoder runs in the boot state `BOOT_ALL`, in which bank 0 claims every request. The first write to bank 0's option fields takes it through the transition `boot_exit` to the state `DECODE_NORMAL`. It stays in `DECODE_NORMAL` until the next reset.

Top module: `bank_select_decoder`

## Requirements
- R1: A bank's address compare uses req_addr[31:15] (compare bit k is req_addr[15+k]). A bank matches only if every compare bit whose mask bit is 1 equals the same bit of its base, and compare bits with mask bit 0 are ignored.
- R2: A bank's type compare takes the request type XOR the bank's type code, ANDed with the bank's 3-bit type mask, and requires the result to be zero. A type mask of 000 therefore accepts any type.
- R3: Outside boot, a bank whose valid flag is 0 never matches.
- R4: When several banks match, the one with the lowest index is chosen. sel_cs has at most one bit set, and that bit is bit sel_bank.
- R5: If the chosen bank is write-protected and the request is a write, the access is refused: sel_hit is 0 and sel_cs is 0 in the result cycle. No other bank takes the access instead.
- R6: A refused write sets bit n of wp_err, where n is the refused bank. The bit stays set until err_clr_we is asserted with err_clr bit n equal to 1. A 0 in err_clr leaves the bit unchanged. A refusal and a clear of the same bit in one cycle leave the bit set.
- R7: In BOOT_ALL, bank 0 is chosen for every request. Its address, type, valid flag and write protection are all ignored, and no error is logged.
- R8: boot_exit happens on the first opt_we with cfg_bank equal to 0, and boot_active falls one cycle later. Base writes and option writes to other banks leave boot unchanged. DECODE_NORMAL is never left except by reset.
- R9: When req_ext is 1, the request type is taken as 3'b100 and req_addr[31:24] as zero before comparing.
- R10: The outputs of a request on clock edge t appear after edge t and hold until edge t+1. A cycle with req_valid low gives sel_hit 0, sel_cs 0 and sel_bank 0. The index is also 0 when nothing is selected.
- R11: While reset is active: sel_hit, sel_cs, sel_bank and wp_err are 0, boot_active is 1, and all bank valid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Request address |
| req_type | input | 3 | Request address type |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ext | input | 1 | Request issued by an external bus master |
| base_we | input | 1 | Load base fields of bank cfg_bank |
| opt_we | input | 1 | Load option fields of bank cfg_bank |
| cfg_bank | input | 2 | Bank addressed by a configuration write |
| cfg_base | input | 17 | Base address value |
| cfg_type | input | 3 | Address-type code value |
| cfg_wprot | input | 1 | Write-protect flag value |
| cfg_valid | input | 1 | Valid flag value |
| cfg_mask | input | 17 | Address compare mask value |
| cfg_type_mask | input | 3 | Type compare mask value |
| err_clr_we | input | 1 | Apply err_clr to the error vector |
| err_clr | input | 4 | Write-one-to-clear bits for wp_err |
| sel_hit | output | 1 | Registered: a bank was selected |
| sel_cs | output | 4 | Registered one-hot chip-select enable |
| sel_bank | output | 2 | Registered index of the selected bank |
| wp_err | output | 4 | Sticky write-protect error per bank |
| boot_active | output | 1 | Decoder is in BOOT_ALL |

## Verification
Two events can hit the error vector in the same cycle: a refused write setting bit n, and a software clear with err_clr bit n at 1. The bench drives both on one edge. It also drives a clear with a zero mask, and a clear together with a refusal on a different bank. A behavioural model decides each edge on its own terms, applying the clear first and the set last. The model is compared with wp_err, and with the chip-select outputs of the same request, on every clock. Boot exit combined with a simultaneous request is provoked the same way: the request must still be decoded in BOOT_ALL.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
    localparam int BSD_AT_W = 3;
    localparam logic [BSD_AT_W-1:0] BSD_EXT_TYPE = 3'b100;

    typedef enum logic {
        BOOT_ALL      = 1'b0,
        DECODE_NORMAL = 1'b1
    } bsd_mode_e;
endpackage

// File: rtl/bsd_bank_match.sv
module bsd_bank_match #(
    parameter int CMP_W = 17,
    parameter int AT_W  = 3
) (
    input  logic [CMP_W-1:0] cmp_addr,
    input  logic [AT_W-1:0]  cmp_type,
    input  logic [CMP_W-1:0] base,
    input  logic [CMP_W-1:0] mask,
    input  logic [AT_W-1:0]  type_code,
    input  logic [AT_W-1:0]  type_mask,
    input  logic             valid,
    input  logic             force_hit,
    output logic             hit
);
    logic addr_ok;
    logic type_ok;

    always_comb begin
        addr_ok = ((cmp_addr ^ base) & mask) == '0;
        type_ok = ((cmp_type ^ type_code) & type_mask) == '0;
        hit     = force_hit | (valid & addr_ok & type_ok);
    end
endmodule

// File: rtl/bsd_prio_pick.sv
module bsd_prio_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hits,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found  = 1'b1;
                idx    = IW'(i);
                onehot = N'(1) << i;
            end
        end
    end

    always_comb begin
        assert_pick_onehot_R4: assert ($onehot0(onehot));
    end
endmodule

// File: rtl/bsd_err_status.sv
module bsd_err_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] err_q
);
    logic [N-1:0] clr_eff;

    always_comb clr_eff = clr_we ? clr_vec : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~clr_eff) | set_vec;
    end

    assert_err_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((err_q & $past(set_vec)) == $past(set_vec)));

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((clr_vec & ~set_vec) != '0)) |=> ((err_q & $past(clr_vec & ~set_vec)) == '0));

    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we) |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/bank_select_decoder.sv
module bank_select_decoder #(
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_W     = 32,
    parameter int CMP_W      = 17,
    parameter int EXT_ZERO_W = 8,
    localparam int AT_W      = bsd_pkg::BSD_AT_W,
    localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [AT_W-1:0]      req_type,
    input  logic                 req_write,
    input  logic                 req_ext,
    input  logic                 base_we,
    input  logic                 opt_we,
    input  logic [IDX_W-1:0]     cfg_bank,
    input  logic [CMP_W-1:0]     cfg_base,
    input  logic [AT_W-1:0]      cfg_type,
    input  logic                 cfg_wprot,
    input  logic                 cfg_valid,
    input  logic [CMP_W-1:0]     cfg_mask,
    input  logic [AT_W-1:0]      cfg_type_mask,
    input  logic                 err_clr_we,
    input  logic [NUM_BANKS-1:0] err_clr,
    output logic                 sel_hit,
    output logic [NUM_BANKS-1:0] sel_cs,
    output logic [IDX_W-1:0]     sel_bank,
    output logic [NUM_BANKS-1:0] wp_err,
    output logic                 boot_active
);
    import bsd_pkg::*;

    bsd_mode_e state_q, state_d;
    logic      boot_on;

    logic [CMP_W-1:0] base_q [NUM_BANKS];
    logic [CMP_W-1:0] mask_q [NUM_BANKS];
    logic [AT_W-1:0]  at_q   [NUM_BANKS];
    logic [AT_W-1:0]  atm_q  [NUM_BANKS];
    logic             wp_q   [NUM_BANKS];
    logic             val_q  [NUM_BANKS];

    logic [ADDR_W-1:0]    eff_addr;
    logic [AT_W-1:0]      eff_type;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [NUM_BANKS-1:0] prot_eff;
    logic                 found;
    logic [IDX_W-1:0]     win_idx;
    logic [NUM_BANKS-1:0] win_oh;
    logic                 blocked;
    logic                 grant;
    logic [NUM_BANKS-1:0] err_set;

    assign boot_on     = (state_q == BOOT_ALL);
    assign boot_active = boot_on;

    // external requests: type forced, top address bits seen as zero
    always_comb begin
        eff_addr = req_ext ? {{EXT_ZERO_W{1'b0}}, req_addr[ADDR_W-EXT_ZERO_W-1:0]} : req_addr;
        eff_type = req_ext ? BSD_EXT_TYPE : req_type;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic force_b;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                at_q[g]   <= '0;
                wp_q[g]   <= 1'b0;
                val_q[g]  <= 1'b0;
                mask_q[g] <= '0;
                atm_q[g]  <= '0;
            end else begin
                if (base_we && cfg_bank == IDX_W'(g)) begin
                    base_q[g] <= cfg_base;
                    at_q[g]   <= cfg_type;
                    wp_q[g]   <= cfg_wprot;
                    val_q[g]  <= cfg_valid;
                end
                if (opt_we && cfg_bank == IDX_W'(g)) begin
                    mask_q[g] <= cfg_mask;
                    atm_q[g]  <= cfg_type_mask;
                end
            end
        end

        if (g == 0) begin : g_boot
            assign force_b = boot_on;
        end else begin : g_plain
            assign force_b = 1'b0;
        end

        assign prot_eff[g] = wp_q[g] & ~force_b;

        bsd_bank_match #(.CMP_W(CMP_W), .AT_W(AT_W)) u_match (
            .cmp_addr  (eff_addr[ADDR_W-1 -: CMP_W]),
            .cmp_type  (eff_type),
            .base      (base_q[g]),
            .mask      (mask_q[g]),
            .type_code (at_q[g]),
            .type_mask (atm_q[g]),
            .valid     (val_q[g]),
            .force_hit (force_b),
            .hit       (bank_hit[g])
        );
    end

    bsd_prio_pick #(.N(NUM_BANKS)) u_pick (
        .hits   (bank_hit),
        .found  (found),
        .idx    (win_idx),
        .onehot (win_oh)
    );

    always_comb begin
        blocked = req_valid & req_write & found & prot_eff[win_idx];
        grant   = req_valid & found & ~blocked;
        err_set = blocked ? win_oh : '0;
    end

    bsd_err_status #(.N(NUM_BANKS)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (err_set),
        .clr_we  (err_clr_we),
        .clr_vec (err_clr),
        .err_q   (wp_err)
    );

    // mode next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BOOT_ALL:      if (opt_we && cfg_bank == '0) state_d = DECODE_NORMAL;
            DECODE_NORMAL: state_d = DECODE_NORMAL;
            default:       state_d = BOOT_ALL;
        endcase
    end

    // mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BOOT_ALL;
        else        state_q <= state_d;
    end

    // registered select outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_hit  <= 1'b0;
            sel_cs   <= '0;
            sel_bank <= '0;
        end else begin
            sel_hit  <= grant;
            sel_cs   <= grant ? win_oh : '0;
            sel_bank <= grant ? win_idx : '0;
        end
    end

    assert_idle_no_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid) |=> (!sel_hit && sel_cs == '0));

    assert_boot_takes_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_active && req_valid) |=> (sel_hit && sel_cs[0]));

    assert_boot_no_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_active) |=> (!boot_active));

    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_cs));

    assert_refused_no_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked) |=> (!sel_hit && $rose(wp_err[$past(win_idx)]) || wp_err[$past(win_idx)]));
endmodule

// File: tb/sim_bank_select_decoder.sv
module sim_bank_select_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_ext = 0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_type = '0;
    logic        base_we = 0, opt_we = 0;
    logic [1:0]  cfg_bank = '0;
    logic [16:0] cfg_base = '0, cfg_mask = '0;
    logic [2:0]  cfg_type = '0, cfg_type_mask = '0;
    logic        cfg_wprot = 0, cfg_valid = 0;
    logic        err_clr_we = 0;
    logic [3:0]  err_clr = '0;
    logic        sel_hit, boot_active;
    logic [3:0]  sel_cs, wp_err;
    logic [1:0]  sel_bank;

    always #10 clk = ~clk;

    bank_select_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_type(req_type), .req_write(req_write), .req_ext(req_ext),
        .base_we(base_we), .opt_we(opt_we), .cfg_bank(cfg_bank), .cfg_base(cfg_base),
        .cfg_type(cfg_type), .cfg_wprot(cfg_wprot), .cfg_valid(cfg_valid),
        .cfg_mask(cfg_mask), .cfg_type_mask(cfg_type_mask), .err_clr_we(err_clr_we),
        .err_clr(err_clr), .sel_hit(sel_hit), .sel_cs(sel_cs), .sel_bank(sel_bank),
        .wp_err(wp_err), .boot_active(boot_active)
    );

    int checks = 0;
    int fails = 0;
    string cur_req = "R11";
    bit started = 0;

    // behavioural reference model
    logic [16:0] m_base [4];
    logic [16:0] m_mask [4];
    logic [2:0]  m_at [4];
    logic [2:0]  m_atm [4];
    bit          m_wp [4];
    bit          m_val [4];
    bit          m_boot = 1;
    logic [3:0]  m_err = '0;
    bit          exp_hit = 0, exp_boot = 1;
    logic [3:0]  exp_cs = '0, exp_err = '0;
    logic [1:0]  exp_bank = '0;
    logic [31:0] ea;
    logic [2:0]  et;
    int          win;
    logic [3:0]  nerr;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_base[i] = '0; m_mask[i] = '0; m_at[i] = '0; m_atm[i] = '0;
                m_wp[i] = 0; m_val[i] = 0;
            end
            m_boot = 1; m_err = '0;
            exp_hit = 0; exp_cs = '0; exp_bank = '0; exp_err = '0; exp_boot = 1;
        end else begin
            ea = req_ext ? {8'h00, req_addr[23:0]} : req_addr;
            et = req_ext ? 3'b100 : req_type;
            win = -1;
            for (int b = 0; b < 4; b++) begin
                if (win < 0) begin
                    if ((b == 0 && m_boot) ||
                        (m_val[b] && (((ea[31:15] ^ m_base[b]) & m_mask[b]) == 0) &&
                         (((et ^ m_at[b]) & m_atm[b]) == 0)))
                        win = b;
                end
            end
            nerr = m_err;
            if (err_clr_we) nerr = nerr & ~err_clr;
            exp_hit = 0; exp_cs = '0; exp_bank = '0;
            if (req_valid && win >= 0) begin
                if (req_write && m_wp[win] && !(win == 0 && m_boot)) nerr[win] = 1'b1;
                else begin
                    exp_hit = 1; exp_cs = 4'b0001 << win; exp_bank = 2'(win);
                end
            end
            m_err = nerr; exp_err = nerr;
            if (base_we) begin
                m_base[cfg_bank] = cfg_base; m_at[cfg_bank] = cfg_type;
                m_wp[cfg_bank] = cfg_wprot; m_val[cfg_bank] = cfg_valid;
            end
            if (opt_we) begin
                m_mask[cfg_bank] = cfg_mask; m_atm[cfg_bank] = cfg_type_mask;
                if (cfg_bank == 2'd0) m_boot = 0;
            end
            exp_boot = m_boot;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("sel_hit", 32'(sel_hit), 32'(exp_hit));
            chk("sel_cs", 32'(sel_cs), 32'(exp_cs));
            chk("sel_bank", 32'(sel_bank), 32'(exp_bank));
            chk("wp_err", 32'(wp_err), 32'(exp_err));
            chk("boot_active", 32'(boot_active), 32'(exp_boot));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(input logic [31:0] a, input logic [2:0] t, input bit w, input bit e);
        req_valid = 1; req_addr = a; req_type = t; req_write = w; req_ext = e;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_ext = 0;
    endtask

    task automatic wbase(input logic [1:0] b, input logic [16:0] base, input logic [2:0] t,
                         input bit wp, input bit v);
        base_we = 1; cfg_bank = b; cfg_base = base; cfg_type = t; cfg_wprot = wp; cfg_valid = v;
        @(negedge clk);
        base_we = 0;
    endtask

    task automatic wopt(input logic [1:0] b, input logic [16:0] m, input logic [2:0] tm);
        opt_we = 1; cfg_bank = b; cfg_mask = m; cfg_type_mask = tm;
        @(negedge clk);
        opt_we = 0;
    endtask

    task automatic clr(input logic [3:0] m);
        err_clr_we = 1; err_clr = m;
        @(negedge clk);
        err_clr_we = 0; err_clr = '0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        cur_req = "R11";
        idle(3);
        rst_n = 1;
        idle(2);

        cur_req = "R7";
        req(32'hDEAD_BEEF, 3'b010, 0, 0);
        req(32'h1234_5678, 3'b111, 1, 0);
        cur_req = "R8";
        wbase(2'd0, 17'h00000, 3'b000, 1, 0);
        req(32'hFFFF_0000, 3'b001, 1, 0);   // still boot: wp and valid ignored
        wopt(2'd1, 17'h1FF00, 3'b000);
        req(32'h0000_0004, 3'b000, 0, 1);
        // boot exit in the same cycle as a request
        opt_we = 1; cfg_bank = 2'd0; cfg_mask = 17'h1FFFF; cfg_type_mask = 3'b000;
        req_valid = 1; req_addr = 32'h7777_0000; req_type = 3'b000; req_write = 1;
        @(negedge clk);
        opt_we = 0; req_valid = 0; req_write = 0;
        req(32'h0000_0000, 3'b000, 0, 0);   // bank0 invalid now: no match
        wopt(2'd0, 17'h1FFFF, 3'b000);       // second write: no return to boot
        wbase(2'd0, 17'h00002, 3'b000, 0, 1);
        req(32'h0001_0000, 3'b000, 0, 0);

        cur_req = "R1";
        wbase(2'd1, 17'h00100, 3'b010, 0, 1);
        wopt(2'd1, 17'h1FF00, 3'b110);
        req(32'h0080_0000, 3'b010, 0, 0);
        req(32'h0080_8000, 3'b011, 0, 0);   // masked compare bit 0 differs
        req(32'h00FF_8000, 3'b010, 0, 0);   // all masked bits differ
        req(32'h0180_0000, 3'b010, 0, 0);   // compared bit differs
        req(32'h0001_0000, 3'b111, 0, 0);

        cur_req = "R2";
        req(32'h0080_0000, 3'b000, 0, 0);   // type bit 1 mismatch
        req(32'h0080_0000, 3'b110, 0, 0);
        wbase(2'd3, 17'h00000, 3'b101, 0, 1);
        wopt(2'd3, 17'h00000, 3'b000);       // zero type mask: any type
        req(32'h5555_0000, 3'b011, 0, 0);
        wopt(2'd3, 17'h00000, 3'b111);
        req(32'h5555_0000, 3'b011, 0, 0);
        req(32'h5555_0000, 3'b101, 0, 0);

        cur_req = "R3";
        wbase(2'd1, 17'h00100, 3'b010, 0, 0);
        req(32'h0080_0000, 3'b010, 0, 0);
        wbase(2'd1, 17'h00100, 3'b010, 0, 1);

        cur_req = "R4";
        wbase(2'd2, 17'h00100, 3'b010, 0, 1);
        wopt(2'd2, 17'h1FFFF, 3'b000);
        wopt(2'd3, 17'h00000, 3'b000);
        req(32'h0080_0000, 3'b010, 0, 0);   // banks 1,2,3 match
        req(32'h0080_0000, 3'b000, 0, 0);   // banks 2,3 match
        req(32'h0001_0000, 3'b000, 0, 0);   // banks 0,3 match
        req(32'h9999_0000, 3'b000, 1, 0);

        cur_req = "R5";
        wbase(2'd1, 17'h00100, 3'b010, 1, 1);
        req(32'h0080_0000, 3'b010, 1, 0);   // bank1 refuses; bank2 must not take it
        req(32'h0080_0000, 3'b010, 0, 0);   // read still granted

        cur_req = "R6";
        clr(4'b0000);
        clr(4'b1101);
        idle(1);
        clr(4'b0010);
        req(32'h0080_0000, 3'b010, 1, 0);
        err_clr_we = 1; err_clr = 4'b0010;   // set and clear same bit
        req_valid = 1; req_addr = 32'h0080_0000; req_type = 3'b010; req_write = 1;
        @(negedge clk);
        req_valid = 0; req_write = 0; err_clr_we = 0; err_clr = '0;
        wbase(2'd0, 17'h00002, 3'b000, 1, 1);
        req(32'h0001_0000, 3'b000, 1, 0);
        err_clr_we = 1; err_clr = 4'b0001;  // clear bank0 while bank1 refused
        req_valid = 1; req_addr = 32'h0080_0000; req_type = 3'b010; req_write = 1;
        @(negedge clk);
        req_valid = 0; req_write = 0; err_clr_we = 0; err_clr = '0;
        clr(4'b1111);

        cur_req = "R9";
        wbase(2'd3, 17'h00000, 3'b100, 0, 1);
        wopt(2'd3, 17'h1FE00, 3'b111);
        req(32'hFF00_0000, 3'b000, 0, 1);
        req(32'hFF00_0000, 3'b100, 0, 0);
        req(32'hAB12_3456, 3'b011, 0, 1);
        req(32'h0012_3456, 3'b011, 0, 0);

        cur_req = "R10";
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            a = $urandom;
            case ($urandom % 4)
                0: a = {9'h001, a[22:0]};
                1: a = {15'h0002, a[16:0]};
                2: a = {8'h00, a[23:0]};
                default: ;
            endcase
            if ($urandom % 5 == 0) begin
                err_clr_we = 1; err_clr = 4'($urandom);
            end
            if ($urandom % 4 != 0) begin
                req_valid = 1; req_addr = a; req_type = 3'($urandom);
                req_write = 1'($urandom); req_ext = 1'($urandom);
            end
            @(negedge clk);
            req_valid = 0; req_write = 0; req_ext = 0; err_clr_we = 0; err_clr = '0;
        end
        idle(3);
        summary();
    end
endmodule